// File: doc/BRIEF.md
# PCI Window DMA Address Translator

This block turns a 32-bit PCI bus address into a 34-bit DMA address. It holds four programmable address windows. Each window has a base, a size mask and a translated-base register, written and read through a simple 64-bit register port. An incoming bus address is compared against every window. The enabled window with the lowest index that matches produces the translation.

A window works in one of two modes. In direct mode the translated address is formed at once from the translated base and the low bus-address bits. In scatter-gather mode the block computes the address of an 8-byte page-table entry and fetches it with a single memory read over a valid/ready request and a response strobe. It then builds the DMA address from the returned entry. Only one fetch is outstanding at a time. While the fetch is pending, the translation input is closed.

Each translation ends with a one-cycle done pulse and a hit flag. When no enabled window matches, the result is a miss with a zero address.

Top module: `pci_win_xlate`

## Requirements
- R1: After reset all twelve window registers read as zero.
- R2: The register index is (reg_addr - DEV_BASE) >> 6. Indices 0-3 are the window bases, 4-7 the window masks, 8-11 the translated bases, 12 is the control register and 13 is the invalidate-all register. A legal read returns the stored 64-bit value on reg_rdata with reg_rvalid, one cycle after the request.
- R3: The control register and the invalidate-all register both read as zero. Writes to either change no state.
- R4: An access is illegal when reg_size is not 3 (3 means 8 bytes; 0, 1 and 2 mean 1, 2 and 4 bytes), when the index is above 13, or when reg_addr is below DEV_BASE. An illegal access raises reg_err for one cycle, one cycle after the request. An illegal read returns zero and an illegal write changes no register.
- R5: The compare mask of a window is ~mask & 0x7ff00000, which covers bus bits 30:20. The window matches when the bus address and the base agree under this compare mask.
- R6: Base bit 0 enables a window and base bit 1 selects scatter-gather mode. A matching window that is disabled is skipped. Among enabled matching windows, the lowest index wins.
- R7: Direct mode uses a pass mask of (mask & 0x7ff00000) | 0xfffff. The DMA address takes the bus bits under the pass mask and all other bits from the translated base. xl_done and xl_hit are high in the cycle after the request.
- R8: In scatter-gather mode the entry address is (tba & ~(((mask & 0x7ff00000) >> 10) | 0x3ff)) | ((bus & ((mask & 0x7ff00000) | 0xfe000)) >> 10). This address is put on mem_req_addr with mem_req_valid. Both are held steady until mem_req_ready is seen.
- R9: After the fetch, the DMA address is ((entry with bit 0 cleared) << 12) | bus[12:0]. It is presented with xl_done and xl_hit in the cycle after mem_rsp_valid.
- R10: Every translated address is truncated to bits 33:0.
- R11: A request that hits no enabled window gives xl_done with xl_hit low and xl_dma zero, one cycle after the request.
- R12: From the acceptance of a scatter-gather request until its response arrives, xl_ready is low. Requests offered in that interval are ignored and produce no result.
- R13: A translation requested in the same cycle as a register write uses the register values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access size code (3 = 8 bytes) |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the access |
| reg_rvalid | output | 1 | Read data valid pulse |
| reg_err | output | 1 | Illegal access pulse |
| xl_req | input | 1 | Translation request |
| xl_addr | input | BUS_W | PCI bus address to translate |
| xl_ready | output | 1 | Translator accepts a request |
| xl_done | output | 1 | Result pulse |
| xl_hit | output | 1 | Result came from a window |
| xl_dma | output | DMA_W | Translated DMA address |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Page-table entry address |
| mem_rsp_valid | input | 1 | Page-table entry returned |
| mem_rsp_data | input | 64 | Page-table entry |

## Verification
Two functions can coincide in a single cycle: a register write to a window and a translation request that reads that same window. The bench provokes this by driving a write to a window's translated base in the same cycle as a request that hits that window. The result must carry the old base, and the next request must carry the new one. A second overlap is a request offered while a page-table fetch is pending, at the very edge where the response arrives. That request must be dropped without producing a second done pulse.

// File: rtl/pci_xlate_pkg.sv
// Package: shared state type and field constants for the window translator.
// Assumes 64-bit registers and 64-byte register spacing.
package pci_xlate_pkg;
    localparam logic [63:0] WIN_FIELD = 64'h0000_0000_7FF0_0000; // bits 30:20
    localparam logic [1:0]  SZ_8B     = 2'd3;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pci_xlate_regs.sv
// Register file for all windows: decode, write, registered read-back and error pulse.
// Assumes one access per cycle; the index is the byte offset from DEV_BASE divided by 64.
module pci_xlate_regs #(
    parameter int          NUM_WIN  = 4,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] DEV_BASE = 16'h1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_valid,
    input  logic                      reg_we,
    input  logic [1:0]                reg_size,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [63:0]               reg_wdata,
    output logic [63:0]               reg_rdata,
    output logic                      reg_rvalid,
    output logic                      reg_err,
    output logic [NUM_WIN-1:0][63:0]  base_q,
    output logic [NUM_WIN-1:0][63:0]  mask_q,
    output logic [NUM_WIN-1:0][63:0]  tba_q
);
    import pci_xlate_pkg::*;

    localparam int IDX_W     = ADDR_W - 6;
    localparam int IDX_MASK0 = NUM_WIN;
    localparam int IDX_TBA0  = 2 * NUM_WIN;
    localparam int IDX_CTRL  = 3 * NUM_WIN;
    localparam int IDX_INVAL = 3 * NUM_WIN + 1;

    logic [ADDR_W-1:0] offs;
    logic [IDX_W-1:0]  idx;
    logic              legal;
    logic [63:0]       rd_next;

    // Offset and index from the byte address; legality of size and index.
    always_comb begin
        offs  = reg_addr - ADDR_W'(DEV_BASE);
        idx   = offs[ADDR_W-1:6];
        legal = (reg_size == SZ_8B) && (reg_addr >= ADDR_W'(DEV_BASE))
                && (idx <= IDX_W'(IDX_INVAL));
    end

    // Read multiplexer; control, invalidate and illegal accesses read zero.
    always_comb begin
        rd_next = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (idx == IDX_W'(w))             rd_next = base_q[w];
            if (idx == IDX_W'(IDX_MASK0 + w)) rd_next = mask_q[w];
            if (idx == IDX_W'(IDX_TBA0 + w))  rd_next = tba_q[w];
        end
        if (!legal || idx == IDX_W'(IDX_CTRL)) rd_next = '0;
    end

    // Window register storage; only legal writes update it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            tba_q  <= '0;
        end else if (reg_valid && reg_we && legal) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (idx == IDX_W'(w))             base_q[w] <= reg_wdata;
                if (idx == IDX_W'(IDX_MASK0 + w)) mask_q[w] <= reg_wdata;
                if (idx == IDX_W'(IDX_TBA0 + w))  tba_q[w]  <= reg_wdata;
            end
        end
    end

    // Registered read response and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
            reg_err    <= 1'b0;
        end else begin
            reg_rvalid <= reg_valid && !reg_we;
            reg_err    <= reg_valid && !legal;
            if (reg_valid && !reg_we) reg_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/pci_xlate_window.sv
// One window: match test, direct-mode result and page-table entry address.
// Purely combinational; assumes the bus address is zero-extended to 64 bits.
module pci_xlate_window #(
    parameter int BUS_W = 32,
    parameter int DMA_W = 34
) (
    input  logic [63:0]      base,
    input  logic [63:0]      mask,
    input  logic [63:0]      tba,
    input  logic [BUS_W-1:0] bus,
    output logic             hit,
    output logic             sg,
    output logic [DMA_W-1:0] direct_dma,
    output logic [63:0]      pte_addr
);
    import pci_xlate_pkg::*;

    logic [63:0] bus64, size_f, cmp_m, pass_m, dir64;

    // Window compare, direct translation and entry address.
    always_comb begin
        bus64      = 64'(bus);
        size_f     = mask & WIN_FIELD;
        cmp_m      = ~mask & WIN_FIELD;
        hit        = base[0] && ((bus64 & cmp_m) == (base & cmp_m));
        sg         = base[1];
        pass_m     = size_f | 64'h0000_0000_000F_FFFF;
        dir64      = (tba & ~pass_m) | (bus64 & pass_m);
        direct_dma = dir64[DMA_W-1:0];
        pte_addr   = (tba & ~((size_f >> 10) | 64'h3FF))
                   | ((bus64 & (size_f | 64'h0000_0000_000F_E000)) >> 10);
    end
endmodule

// File: rtl/pci_xlate_seq.sv
// Priority pick among windows and the translation sequencer with one page-table fetch.
// Assumes the memory response arrives only after the request was accepted.
module pci_xlate_seq #(
    parameter int NUM_WIN = 4,
    parameter int DMA_W   = 34
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_WIN-1:0]              hit_vec,
    input  logic [NUM_WIN-1:0]              sg_vec,
    input  logic [NUM_WIN-1:0][DMA_W-1:0]   dir_vec,
    input  logic [NUM_WIN-1:0][63:0]        pte_vec,
    input  logic                            xl_req,
    input  logic [12:0]                     xl_low,
    output logic                            xl_ready,
    output logic                            xl_done,
    output logic                            xl_hit,
    output logic [DMA_W-1:0]                xl_dma,
    output logic                            mem_req_valid,
    input  logic                            mem_req_ready,
    output logic [63:0]                     mem_req_addr,
    input  logic                            mem_rsp_valid,
    input  logic [63:0]                     mem_rsp_data
);
    import pci_xlate_pkg::*;

    seq_state_e       state;
    logic             sel_found, sel_sg;
    logic [DMA_W-1:0] sel_dir;
    logic [63:0]      sel_pte, sg64;
    logic [12:0]      low_q;

    // Lowest-index enabled matching window wins.
    always_comb begin
        sel_found = 1'b0;
        sel_sg    = 1'b0;
        sel_dir   = '0;
        sel_pte   = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                sel_found = 1'b1;
                sel_sg    = sg_vec[w];
                sel_dir   = dir_vec[w];
                sel_pte   = pte_vec[w];
            end
        end
    end

    // Scatter-gather result from the returned entry.
    always_comb begin
        sg64 = ((mem_rsp_data & ~64'h1) << 12) | 64'(low_q);
    end

    assign xl_ready      = (state == SQ_IDLE);
    assign mem_req_valid = (state == SQ_REQ);

    // Sequencer: accept, fetch the entry if needed, deliver the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SQ_IDLE;
            xl_done      <= 1'b0;
            xl_hit       <= 1'b0;
            xl_dma       <= '0;
            mem_req_addr <= '0;
            low_q        <= '0;
        end else begin
            xl_done <= 1'b0;
            case (state)
                SQ_IDLE: if (xl_req) begin
                    if (sel_found && sel_sg) begin
                        state        <= SQ_REQ;
                        mem_req_addr <= sel_pte;
                        low_q        <= xl_low;
                    end else begin
                        xl_done <= 1'b1;
                        xl_hit  <= sel_found;
                        xl_dma  <= sel_found ? sel_dir : '0;
                    end
                end
                SQ_REQ: if (mem_req_ready) state <= SQ_WAIT;
                SQ_WAIT: if (mem_rsp_valid) begin
                    state   <= SQ_IDLE;
                    xl_done <= 1'b1;
                    xl_hit  <= 1'b1;
                    xl_dma  <= sg64[DMA_W-1:0];
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pci_win_xlate.sv
// Top: PCI bus address to DMA address translator with programmable windows.
// Assumes 64-bit register accesses and a single outstanding page-table read.
module pci_win_xlate #(
    parameter int          NUM_WIN  = 4,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] DEV_BASE = 16'h1000,
    parameter int          BUS_W    = 32,
    parameter int          DMA_W    = 34
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_valid,
    input  logic               reg_we,
    input  logic [1:0]         reg_size,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    output logic               reg_rvalid,
    output logic               reg_err,
    input  logic               xl_req,
    input  logic [BUS_W-1:0]   xl_addr,
    output logic               xl_ready,
    output logic               xl_done,
    output logic               xl_hit,
    output logic [DMA_W-1:0]   xl_dma,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [63:0]        mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [63:0]        mem_rsp_data
);
    logic [NUM_WIN-1:0][63:0]      base_q, mask_q, tba_q, pte_vec;
    logic [NUM_WIN-1:0]            hit_vec, sg_vec;
    logic [NUM_WIN-1:0][DMA_W-1:0] dir_vec;

    pci_xlate_regs #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .DEV_BASE(DEV_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_we(reg_we),
        .reg_size(reg_size), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .reg_err(reg_err),
        .base_q(base_q), .mask_q(mask_q), .tba_q(tba_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        pci_xlate_window #(.BUS_W(BUS_W), .DMA_W(DMA_W)) u_win (
            .base(base_q[w]), .mask(mask_q[w]), .tba(tba_q[w]), .bus(xl_addr),
            .hit(hit_vec[w]), .sg(sg_vec[w]), .direct_dma(dir_vec[w]),
            .pte_addr(pte_vec[w])
        );
    end

    pci_xlate_seq #(.NUM_WIN(NUM_WIN), .DMA_W(DMA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .sg_vec(sg_vec),
        .dir_vec(dir_vec), .pte_vec(pte_vec), .xl_req(xl_req),
        .xl_low(xl_addr[12:0]), .xl_ready(xl_ready), .xl_done(xl_done),
        .xl_hit(xl_hit), .xl_dma(xl_dma), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );
endmodule

// File: rtl/pci_win_xlate_chk.sv
// Checker: protocol and timing properties of the translator, bound to the top.
// Assumes the same parameter values as the instance it is bound to.
module pci_win_xlate_chk #(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 32,
    parameter int DMA_W  = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_we,
    input logic              reg_rvalid,
    input logic              reg_err,
    input logic              xl_req,
    input logic              xl_ready,
    input logic              xl_done,
    input logic              xl_hit,
    input logic [DMA_W-1:0]  xl_dma,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [63:0]       mem_req_addr,
    input logic              mem_rsp_valid
);
    p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_valid && !reg_we));

    p_err_after_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_valid));

    p_accept_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && xl_ready) |=> (xl_done || mem_req_valid));

    p_fetch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_sg_done_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && !$past(xl_req && xl_ready)) |-> ($past(mem_rsp_valid) && xl_hit));

    p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && !xl_hit) |-> (xl_dma == '0));

    p_busy_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !xl_ready);
endmodule

bind pci_win_xlate pci_win_xlate_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DMA_W(DMA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_we(reg_we),
    .reg_rvalid(reg_rvalid), .reg_err(reg_err), .xl_req(xl_req),
    .xl_ready(xl_ready), .xl_done(xl_done), .xl_hit(xl_hit), .xl_dma(xl_dma),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/pci_win_xlate_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module pci_win_xlate_tb_top;
    localparam logic [15:0] BASE = 16'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_size = 2'd3;
    logic [15:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_rvalid, reg_err;
    logic        xl_req = 1'b0;
    logic [31:0] xl_addr = '0;
    logic        xl_ready, xl_done, xl_hit;
    logic [33:0] xl_dma;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pci_win_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_we(reg_we),
        .reg_size(reg_size), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .reg_err(reg_err),
        .xl_req(xl_req), .xl_addr(xl_addr), .xl_ready(xl_ready),
        .xl_done(xl_done), .xl_hit(xl_hit), .xl_dma(xl_dma),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ra(input int idx);
        return BASE + 16'(idx * 64);
    endfunction

    function automatic logic [33:0] ref_direct(input logic [31:0] bus, input logic [63:0] m,
                                               input logic [63:0] t);
        logic [63:0] pass, r;
        pass = (m & 64'h7FF0_0000) | 64'hF_FFFF;
        r    = (t & ~pass) | (64'(bus) & pass);
        return r[33:0];
    endfunction

    task automatic reg_acc(input logic we, input int idx, input logic [1:0] sz,
                           input logic [63:0] wd, output logic [63:0] rd, output logic er);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = we; reg_addr = ra(idx); reg_size = sz; reg_wdata = wd;
        @(negedge clk);
        reg_valid = 1'b0; reg_we = 1'b0; reg_size = 2'd3;
        rd = reg_rdata; er = reg_err;
    endtask

    task automatic wr(input int idx, input logic [63:0] wd);
        logic [63:0] d; logic e;
        reg_acc(1'b1, idx, 2'd3, wd, d, e);
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [63:0] exp);
        logic [63:0] d; logic e;
        reg_acc(1'b0, idx, 2'd3, '0, d, e);
        chk(req, d, exp);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 12; i++) wr(i, 64'h0);
    endtask

    // Single-cycle translation: result expected at the next sample point.
    task automatic xlate(input string req, input logic [31:0] bus,
                         input logic exp_hit, input logic [33:0] exp_dma);
        @(negedge clk);
        xl_req = 1'b1; xl_addr = bus;
        @(negedge clk);
        xl_req = 1'b0;
        chk({req, " done"}, 64'(xl_done), 64'd1);
        chk({req, " hit"},  64'(xl_hit),  64'(exp_hit));
        chk({req, " dma"},  64'(xl_dma),  64'(exp_dma));
    endtask

    task automatic t_reset();
        for (int i = 0; i < 12; i++) rd_chk("R1 reset value", i, 64'h0);
        // R6/R11: window 0 matches bus 0 at reset but is disabled
        xlate("R11 reset miss", 32'h0, 1'b0, 34'h0);
    endtask

    task automatic t_regs();
        for (int i = 0; i < 12; i++) wr(i, 64'hA5A5_0000_0000_0000 | 64'(i * 17 + 3));
        for (int i = 0; i < 12; i++)
            rd_chk("R2 read back", i, 64'hA5A5_0000_0000_0000 | 64'(i * 17 + 3));
        wr(12, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R3 control reads zero", 12, 64'h0);
        wr(13, 64'h1234);
        rd_chk("R3 invalidate reads zero", 13, 64'h0);
        rd_chk("R3 no side effect", 0, 64'hA5A5_0000_0000_0003);
    endtask

    task automatic t_bad();
        logic [63:0] d; logic e;
        reg_acc(1'b0, 0, 2'd2, '0, d, e);
        chk("R4 short read err", 64'(e), 64'd1);
        chk("R4 short read data", d, 64'h0);
        reg_acc(1'b1, 0, 2'd1, 64'hDEAD, d, e);
        chk("R4 short write err", 64'(e), 64'd1);
        rd_chk("R4 short write ignored", 0, 64'hA5A5_0000_0000_0003);
        reg_acc(1'b0, 14, 2'd3, '0, d, e);
        chk("R4 undecoded err", 64'(e), 64'd1);
        chk("R4 undecoded data", d, 64'h0);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = 1'b0; reg_addr = BASE - 16'd64; reg_size = 2'd3;
        @(negedge clk);
        reg_valid = 1'b0;
        chk("R4 below base err", 64'(reg_err), 64'd1);
        @(negedge clk);
        chk("R4 err is a pulse", 64'(reg_err), 64'd0);
        reg_acc(1'b0, 5, 2'd3, '0, d, e);
        chk("R4 legal no err", 64'(e), 64'd0);
    endtask

    task automatic t_direct();
        clear_all();
        wr(0, 64'h4000_0001); wr(4, 64'h0010_0000); wr(8, 64'h2_8000_0000);
        xlate("R7 direct", 32'h4012_3456, 1'b1, 34'h2_8012_3456);
        xlate("R5 miss outside window", 32'h5000_0000, 1'b0, 34'h0);
        wr(8, 64'hFFFF_FFFF_0000_0000);
        xlate("R10 direct truncated", 32'h401F_0001,
              1'b1, ref_direct(32'h401F_0001, 64'h0010_0000, 64'hFFFF_FFFF_0000_0000));
    endtask

    task automatic t_prio();
        clear_all();
        wr(0, 64'h4000_0000); wr(4, 64'h0010_0000); wr(8, 64'h3_0000_0000);
        wr(1, 64'h4000_0001); wr(9, 64'h1_0000_0000);
        wr(2, 64'h4000_0001); wr(10, 64'h2_0000_0000);
        xlate("R6 disabled skipped", 32'h4000_3456, 1'b1, 34'h1_0000_3456);
        wr(0, 64'h4000_0001);
        xlate("R6 lowest index wins", 32'h4000_3456, 1'b1,
              ref_direct(32'h4000_3456, 64'h0010_0000, 64'h3_0000_0000));
    endtask

    task automatic t_sg();
        clear_all();
        wr(3, 64'h2000_0003); wr(11, 64'h1_0000_0000);
        @(negedge clk);
        xl_req = 1'b1; xl_addr = 32'h2004_A123; mem_req_ready = 1'b0;
        @(negedge clk);
        xl_addr = 32'h0000_0000;  // further request held high, must be ignored
        chk("R8 fetch issued", 64'(mem_req_valid), 64'd1);
        chk("R8 entry address", mem_req_addr, 64'h1_0000_0128);
        chk("R12 busy", 64'(xl_ready), 64'd0);
        chk("R12 no early done", 64'(xl_done), 64'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 held while stalled", mem_req_addr, 64'h1_0000_0128);
            chk("R8 valid held", 64'(mem_req_valid), 64'd1);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R8 request dropped after ready", 64'(mem_req_valid), 64'd0);
        chk("R12 still busy", 64'(xl_ready), 64'd0);
        @(negedge clk);
        chk("R12 ignored request no done", 64'(xl_done), 64'd0);
        mem_rsp_valid = 1'b1; mem_rsp_data = 64'hFFFF_0000_0012_3457;
        @(negedge clk);
        mem_rsp_valid = 1'b0; xl_req = 1'b0;
        chk("R9 done", 64'(xl_done), 64'd1);
        chk("R9 hit", 64'(xl_hit), 64'd1);
        chk("R9 R10 sg dma", 64'(xl_dma), 64'h1_2345_6123);
        @(negedge clk);
        chk("R12 no extra result", 64'(xl_done), 64'd0);
        chk("R12 ready again", 64'(xl_ready), 64'd1);
    endtask

    task automatic t_same_cycle();
        clear_all();
        wr(0, 64'h4000_0001); wr(4, 64'h0010_0000); wr(8, 64'h1_0000_0000);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = 1'b1; reg_addr = ra(8); reg_size = 2'd3;
        reg_wdata = 64'h3_0000_0000;
        xl_req = 1'b1; xl_addr = 32'h4000_0042;
        @(negedge clk);
        reg_valid = 1'b0; reg_we = 1'b0; xl_req = 1'b0;
        chk("R13 old value used", 64'(xl_dma), 64'h1_0000_0042);
        xlate("R13 new value next", 32'h4000_0042, 1'b1, 34'h3_0000_0042);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_bad();
        t_direct();
        t_prio();
        t_sg();
        t_same_cycle();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule